// File: doc/BRIEF.md
# Pipelined Complex Fixed-Point Multiplier

This block forms the product of two complex numbers held in a fixed-point format. Each operand bus carries two equal-width fields: the real part in the low half and the imaginary part in the high half. The result bus is packed the same way in the output format. Both operand parts share one format, set by the component width, the number of fraction bits and a signed/unsigned choice. The output has its own width and fraction count. The full-precision product is aligned to the output fraction by an arithmetic right shift, which rounds toward minus infinity, and is then cut to the output width.

A build-time parameter picks one of two arithmetic forms. The direct form uses four real products, one subtraction and one addition. The three-product form uses these terms: k1 = br*(ar+ai), k2 = ar*(bi-br), k3 = ai*(br+bi). The real part is then k1-k3 and the imaginary part is k1+k2, which takes five additions or subtractions in total. Both forms run through the same three-register pipeline and give bit-identical outputs. Every intermediate value is one bit wider than the operands it is built from, so no pre-add, product or post-add can overflow.

An enable input freezes the whole pipeline when low, if the enable option is built in. A synchronous reset clears every pipeline register. Products that do not fit the chosen output format give an unspecified value.

Top module: `cmul_top`

## Requirements
- R1: Operand and result buses are packed with the real part in bits [W-1:0] and the imaginary part in bits [2W-1:W], where W is the component width of that bus.
- R2: In the direct form, the result real part is ar*br - ai*bi and the imaginary part is ar*bi + ai*br, taken at full precision with 2*FRAC_W fraction bits.
- R3: The three-product form gives a result bit-identical to the direct form for every input whose product fits the output format.
- R4: The full-precision value is shifted right arithmetically by 2*FRAC_W - OUT_FRAC bits (rounding toward minus infinity), and the low OUT_W bits of the shifted value are output.
- R5: While enable is high, the product of the operands sampled at clock edge n appears on the result after clock edge n+2, which is three register stages, and not earlier.
- R6: While enable is low, no pipeline register changes and the result holds its value. Operands presented during that time are dropped. The pipeline resumes when enable returns high.
- R7: A synchronous reset clears all pipeline registers. The result reads zero during reset and until the first sampled operands reach the output.
- R8: With IS_SIGNED=0 the operand fields are unsigned integers scaled by 2^-FRAC_W. With IS_SIGNED=1 they are two's complement.
- R9: Full-scale operands, such as every signed field at its most negative code, give the exact product with no internal wrap.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| reset | input | 1 | Synchronous reset, active high |
| enable | input | 1 | Pipeline advance; ignored when HAS_ENABLE=0 |
| a | input | 2*DATA_W | Operand A, {imag, real} |
| b | input | 2*DATA_W | Operand B, {imag, real} |
| result | output | 2*OUT_W | Product, {imag, real} |

## Verification
The assertions assume that reset is held high for at least one clock edge before they take effect, and that enable is always a known value. They also assume that the operands are either valid codes or zero, so that a zero factor produces a zero product register. The bench runs four instances: direct and three-product forms with no output shift, a three-product instance with a shifted, narrower output, and an unsigned instance. The signed formats are chosen so that every input fits the output. For the unsigned instance, comparisons are made only on cycles where the expected real part is non-negative, so values that do not fit the format are never checked.

// File: rtl/cmul_pkg.sv
package cmul_pkg;

  // Per-stage load strobes passed from control to datapath.
  typedef struct packed {
    logic loadIn;    // operand / pre-add register stage
    logic loadProd;  // real product register stage
    logic loadOut;   // post-add and output alignment stage
  } cmulStrobes_t;

endpackage

// File: rtl/cmul_ctrl.sv
module cmul_ctrl
  import cmul_pkg::*;
#(
  parameter int HAS_ENABLE = 1
) (
  input  logic         enable,
  output cmulStrobes_t stb
);

  logic advance;

  generate
    if (HAS_ENABLE != 0) begin : g_gated
      assign advance = enable;
    end else begin : g_free
      assign advance = 1'b1;
    end
  endgenerate

  always_comb begin
    stb.loadIn   = advance;
    stb.loadProd = advance;
    stb.loadOut  = advance;
  end

endmodule

// File: rtl/cmul_datapath.sv
module cmul_datapath
  import cmul_pkg::*;
#(
  parameter int DATA_W        = 8,
  parameter int FRAC_W        = 6,
  parameter int IS_SIGNED     = 1,
  parameter int OUT_W         = 18,
  parameter int OUT_FRAC      = 12,
  parameter int USE_KARATSUBA = 0
) (
  input  logic                  clk,
  input  logic                  reset,
  input  cmulStrobes_t          stb,
  input  logic [2*DATA_W-1:0]   opA,
  input  logic [2*DATA_W-1:0]   opB,
  output logic [2*OUT_W-1:0]    prodOut
);

  localparam int OPND_W = DATA_W + 2;           // one guard bit plus one growth bit for the pre-add
  localparam int PROD_W = 2 * OPND_W;
  localparam int SUM_W  = PROD_W + 1;           // growth bit for the post-add
  localparam int SHIFT  = 2 * FRAC_W - OUT_FRAC;
  localparam int NMUL   = (USE_KARATSUBA != 0) ? 3 : 4;
  localparam int WIDE_W = SUM_W + OUT_W;

  function automatic logic signed [OPND_W-1:0] widen(input logic [DATA_W-1:0] v);
    logic extBit;
    extBit = (IS_SIGNED != 0) && v[DATA_W-1];
    return $signed({{2{extBit}}, v});
  endfunction

  logic signed [OPND_W-1:0] aRe, aIm, bRe, bIm;
  assign aRe = widen(opA[DATA_W-1:0]);
  assign aIm = widen(opA[2*DATA_W-1:DATA_W]);
  assign bRe = widen(opB[DATA_W-1:0]);
  assign bIm = widen(opB[2*DATA_W-1:DATA_W]);

  // ---------------- stage 1: operand pairs (with pre-adds) ----------------
  logic signed [OPND_W-1:0] nextX [NMUL];
  logic signed [OPND_W-1:0] nextY [NMUL];
  logic signed [OPND_W-1:0] opX   [NMUL];
  logic signed [OPND_W-1:0] opY   [NMUL];

  generate
    if (USE_KARATSUBA != 0) begin : g_kara_pre
      always_comb begin
        nextX[0] = bRe;
        nextY[0] = aRe + aIm;
        nextX[1] = aRe;
        nextY[1] = bIm - bRe;
        nextX[2] = aIm;
        nextY[2] = bRe + bIm;
      end
    end else begin : g_direct_pre
      always_comb begin
        nextX[0] = aRe;
        nextY[0] = bRe;
        nextX[1] = aIm;
        nextY[1] = bIm;
        nextX[2] = aRe;
        nextY[2] = bIm;
        nextX[3] = aIm;
        nextY[3] = bRe;
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (reset) begin
      for (int i = 0; i < NMUL; i++) begin
        opX[i] <= '0;
        opY[i] <= '0;
      end
    end else if (stb.loadIn) begin
      for (int i = 0; i < NMUL; i++) begin
        opX[i] <= nextX[i];
        opY[i] <= nextY[i];
      end
    end
  end

  // ---------------- stage 2: real products ----------------
  logic signed [PROD_W-1:0] prod [NMUL];

  always_ff @(posedge clk) begin
    if (reset) begin
      for (int i = 0; i < NMUL; i++) prod[i] <= '0;
    end else if (stb.loadProd) begin
      for (int i = 0; i < NMUL; i++) prod[i] <= PROD_W'(opX[i]) * PROD_W'(opY[i]);
    end
  end

  generate
    for (genvar g = 0; g < NMUL; g++) begin : g_prod_chk
      // R2: a zero factor in a loaded pair yields a zero product
      a_r2_zero_factor: assert property (@(posedge clk) disable iff (reset)
        (stb.loadProd && (opX[g] == '0 || opY[g] == '0)) |=> (prod[g] == '0));
      // R6: product stage frozen while its strobe is low
      a_r6_prod_hold: assert property (@(posedge clk) disable iff (reset)
        !stb.loadProd |=> $stable(prod[g]));
    end
  endgenerate

  // ---------------- stage 3: post-adds, alignment, truncation ----------------
  logic signed [SUM_W-1:0] sumRe, sumIm;

  generate
    if (USE_KARATSUBA != 0) begin : g_kara_post
      always_comb begin
        sumRe = SUM_W'(prod[0]) - SUM_W'(prod[2]);
        sumIm = SUM_W'(prod[0]) + SUM_W'(prod[1]);
      end
    end else begin : g_direct_post
      always_comb begin
        sumRe = SUM_W'(prod[0]) - SUM_W'(prod[1]);
        sumIm = SUM_W'(prod[2]) + SUM_W'(prod[3]);
      end
    end
  endgenerate

  logic signed [WIDE_W-1:0] reExt, imExt, reAligned, imAligned;
  always_comb begin
    reExt     = WIDE_W'(sumRe);
    imExt     = WIDE_W'(sumIm);
    reAligned = reExt >>> SHIFT;
    imAligned = imExt >>> SHIFT;
  end

  logic [OUT_W-1:0] resRe, resIm;

  always_ff @(posedge clk) begin
    if (reset) begin
      resRe <= '0;
      resIm <= '0;
    end else if (stb.loadOut) begin
      resRe <= reAligned[OUT_W-1:0];
      resIm <= imAligned[OUT_W-1:0];
    end
  end

  assign prodOut = {resIm, resRe};

  // R7: output stage is zero on the first cycle out of reset
  a_r7_reset_clear: assert property (@(posedge clk) disable iff (reset)
    $fell(reset) |-> (resRe == '0 && resIm == '0));

endmodule

// File: rtl/cmul_top.sv
module cmul_top
  import cmul_pkg::*;
#(
  parameter int DATA_W        = 8,
  parameter int FRAC_W        = 6,
  parameter int IS_SIGNED     = 1,
  parameter int OUT_W         = 18,
  parameter int OUT_FRAC      = 12,
  parameter int USE_KARATSUBA = 0,
  parameter int HAS_ENABLE    = 1
) (
  input  logic                clk,
  input  logic                reset,
  input  logic                enable,
  input  logic [2*DATA_W-1:0] a,
  input  logic [2*DATA_W-1:0] b,
  output logic [2*OUT_W-1:0]  result
);

  cmulStrobes_t stb;

  cmul_ctrl #(
    .HAS_ENABLE(HAS_ENABLE)
  ) ctrl_i (
    .enable(enable),
    .stb   (stb)
  );

  cmul_datapath #(
    .DATA_W       (DATA_W),
    .FRAC_W       (FRAC_W),
    .IS_SIGNED    (IS_SIGNED),
    .OUT_W        (OUT_W),
    .OUT_FRAC     (OUT_FRAC),
    .USE_KARATSUBA(USE_KARATSUBA)
  ) dp_i (
    .clk    (clk),
    .reset  (reset),
    .stb    (stb),
    .opA    (a),
    .opB    (b),
    .prodOut(result)
  );

  generate
    if (HAS_ENABLE != 0) begin : g_hold_chk
      // R6: result frozen while enable is low
      a_r6_hold_result: assert property (@(posedge clk) disable iff (reset)
        !enable |=> $stable(result));
    end
  endgenerate

endmodule

// File: tb/cmul_top_tb_top.sv
`timescale 1ns/1ps
module cmul_top_tb_top;

  localparam int DW = 8;

  logic clk = 1'b0;
  logic reset = 1'b1;
  logic en = 1'b1;
  logic [2*DW-1:0] a = '0;
  logic [2*DW-1:0] b = '0;
  logic [35:0] rDirect, rKara, rUns;
  logic [23:0] rShift;

  int nChecks = 0;
  int nFail = 0;
  bit started = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  cmul_top #(.IS_SIGNED(1), .OUT_W(18), .OUT_FRAC(12), .USE_KARATSUBA(0)) dut_i (
    .clk(clk), .reset(reset), .enable(en), .a(a), .b(b), .result(rDirect));
  cmul_top #(.IS_SIGNED(1), .OUT_W(18), .OUT_FRAC(12), .USE_KARATSUBA(1)) dutKara (
    .clk(clk), .reset(reset), .enable(en), .a(a), .b(b), .result(rKara));
  cmul_top #(.IS_SIGNED(1), .OUT_W(12), .OUT_FRAC(6), .USE_KARATSUBA(1)) dutShift (
    .clk(clk), .reset(reset), .enable(en), .a(a), .b(b), .result(rShift));
  cmul_top #(.IS_SIGNED(0), .OUT_W(18), .OUT_FRAC(12), .USE_KARATSUBA(0)) dutUns (
    .clk(clk), .reset(reset), .enable(en), .a(a), .b(b), .result(rUns));

  function automatic longint part(input logic [7:0] v, input bit sgn);
    return sgn ? longint'($signed(v)) : longint'({56'd0, v});
  endfunction

  function automatic logic [63:0] refProd(input logic [15:0] x, input logic [15:0] y,
                                          input bit sgn, input int shift, input int outw);
    longint xr, xi, yr, yi, re, im;
    logic [63:0] m;
    xr = part(x[7:0], sgn);
    xi = part(x[15:8], sgn);
    yr = part(y[7:0], sgn);
    yi = part(y[15:8], sgn);
    re = (xr * yr - xi * yi) >>> shift;
    im = (xr * yi + xi * yr) >>> shift;
    m  = (64'd1 << outw) - 64'd1;
    return ((64'(im) & m) << outw) | (64'(re) & m);
  endfunction

  function automatic bit unsRealOk(input logic [15:0] x, input logic [15:0] y);
    return (longint'(x[7:0]) * longint'(y[7:0])) >= (longint'(x[15:8]) * longint'(y[15:8]));
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  // Behavioural pipeline model: a queue of sampled operand pairs
  logic [15:0] qA [3];
  logic [15:0] qB [3];

  always @(posedge clk) begin
    if (reset) begin
      for (int i = 0; i < 3; i++) begin
        qA[i] = '0;
        qB[i] = '0;
      end
    end else if (en) begin
      qA[2] = qA[1]; qB[2] = qB[1];
      qA[1] = qA[0]; qB[1] = qB[0];
      qA[0] = a;     qB[0] = b;
    end
  end

  // Per-cycle comparison of every instance against the model
  always @(negedge clk) begin
    if (started && !reset) begin
      check("R2 direct", {28'd0, rDirect}, refProd(qA[2], qB[2], 1'b1, 0, 18));
      check("R3 karatsuba", {28'd0, rKara}, refProd(qA[2], qB[2], 1'b1, 0, 18));
      check("R3 forms equal", {28'd0, rKara}, {28'd0, rDirect});
      check("R4 shifted", {40'd0, rShift}, refProd(qA[2], qB[2], 1'b1, 6, 12));
      if (unsRealOk(qA[2], qB[2]))
        check("R8 unsigned", {28'd0, rUns}, refProd(qA[2], qB[2], 1'b0, 0, 18));
    end
  end

  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", nChecks, nFail);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog act=timeout exp=completion");
    summary();
    $finish;
  end

  initial begin
    logic [35:0] held;
    logic [15:0] vA, vB;
    // R7: result zero while reset is held
    repeat (3) @(negedge clk);
    check("R7 in reset", {28'd0, rDirect}, 64'd0);
    check("R7 in reset kara", {28'd0, rKara}, 64'd0);

    // R5/R7: release reset and present one vector, then zeros
    vA = 16'h4020; vB = 16'h1030;
    reset = 1'b0; a = vA; b = vB; started = 1'b1;
    @(negedge clk); a = '0; b = '0;
    check("R7 zero after reset", {28'd0, rDirect}, 64'd0);
    @(negedge clk);
    check("R5 not early", {28'd0, rDirect}, 64'd0);
    @(negedge clk);
    check("R5 latency", {28'd0, rDirect}, refProd(vA, vB, 1'b1, 0, 18));
    repeat (3) @(negedge clk);

    // R1: real 1.0 times imag 1.0 lands in imag field only
    a = {8'd0, 8'd64}; b = {8'd64, 8'd0};
    repeat (3) @(negedge clk);
    check("R1 real field", {46'd0, rDirect[17:0]}, 64'd0);
    check("R1 imag field", {46'd0, rDirect[35:18]}, 64'd4096);

    // R9: every signed field at most negative code
    a = 16'h8080; b = 16'h8080;
    repeat (3) @(negedge clk);
    check("R9 extreme real", {46'd0, rDirect[17:0]}, 64'd0);
    check("R9 extreme imag", {46'd0, rDirect[35:18]}, 64'd32768);
    check("R9 extreme kara", {28'd0, rKara}, {28'd0, 18'd32768, 18'd0});

    // R6: enable low freezes result and drops operands
    a = 16'h7f81; b = 16'h3c05;
    repeat (3) @(negedge clk);
    held = rDirect;
    en = 1'b0;
    for (int k = 0; k < 5; k++) begin
      a = 16'($urandom); b = 16'($urandom);
      @(negedge clk);
      check("R6 hold", {28'd0, rDirect}, {28'd0, held});
    end
    en = 1'b1;
    a = '0; b = '0;
    repeat (4) @(negedge clk);
    check("R6 resume", {28'd0, rDirect}, 64'd0);

    // Random traffic with enable toggling
    for (int k = 0; k < 600; k++) begin
      a  = 16'($urandom);
      b  = 16'($urandom);
      en = ($urandom % 4) != 0;
      @(negedge clk);
    end
    en = 1'b1;
    repeat (4) @(negedge clk);

    summary();
    $finish;
  end

endmodule